// File: doc/BRIEF.md
# I2C Address Phase Sequencer

This block runs the address phase of an I2C transfer. A requester hands it a target address and a read/write flag in a single cycle. The block checks the address, picks short (7-bit) or long (10-bit) framing from its value, and sends one or two address bytes to a separate byte engine. The first byte carries a START request. The engine reports each byte back with a completion pulse and an error flag, where the error flag stands for a missing acknowledge or a clock-stretch timeout. The sequencer ends with a single done pulse and a 2-bit status.

The byte engine receives one command pulse per byte. The sequencer never asks it for a STOP. The data phase, repeated-start policy and bus timing are handled elsewhere. An address that cannot be framed is rejected before any byte goes out. A long address whose first byte is refused ends at that byte.

Top module: `addr_seq`

## Requirements
- R1: An address below 0x80 that is not reserved is sent as one byte `{addr[6:0], read}` (read flag in bit 0), and `cmdStart` is 1 with that byte.
- R2: An address below 0x80 whose bits 6..3 are all ones (0x78..0x7F) ends with status 1 (invalid), and no command is issued.
- R3: An address of 0x400 or above ends with status 1, and no command is issued.
- R4: An address from 0x80 to 0x3FF is sent as two bytes. The first is `{5'b11110, addr[9:8], read}` with `cmdStart` 1. The second is `addr[7:0]` with `cmdStart` 0.
- R5: If the byte engine reports an error on the first byte of a long address, the sequence ends with status 2 and the second byte is not issued.
- R6: An engine error on the final address byte ends the sequence with status 2.
- R7: Each accepted request produces exactly one `done` pulse, one cycle wide. `status` is 0 for success, 1 for an invalid address and 2 for an engine error.
- R8: `cmdValid` is a one-cycle pulse per byte. A second byte is issued only after the engine has completed the first without error.
- R9: `busy` is high from the cycle after a request is accepted until `done`. A request that arrives while busy has no effect on the transfer in progress.
- R10: An `engDone` pulse while idle produces no `done` and no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when not busy |
| reqAddr | input | AddrW | Target address |
| reqRead | input | 1 | 1 = read transfer, 0 = write |
| busy | output | 1 | Sequence in progress |
| cmdValid | output | 1 | One-cycle byte command to the engine |
| cmdStart | output | 1 | Engine must put a START before this byte |
| cmdByte | output | 8 | Byte to transmit |
| engDone | input | 1 | Engine finished the commanded byte |
| engErr | input | 1 | With engDone: no acknowledge or timeout |
| done | output | 1 | One-cycle end-of-sequence pulse |
| status | output | 2 | Result code, valid with done and held after |

## Verification
The bench applies every 12-bit address with both read flag values while the engine always acknowledges. This separates short framing, the reserved short range, long framing and the out-of-range values at every boundary, including 0x77/0x78, 0x7F/0x80 and 0x3FF/0x400. Two further sweeps over the low 0x480 addresses refuse either the first or the second byte. These sweeps show the early abort on long addresses apart from a plain error on the last byte, and confirm that a second-byte refusal never applies to short addresses. Directed cases send a request into an ongoing sequence and pulse the engine completion while idle.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INVALID = 2'd1,
    ST_BUSERR  = 2'd2
  } seqStatus_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_EVAL  = 2'd1,
    S_WAIT1 = 2'd2,
    S_WAIT2 = 2'd3
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic sendFirst;
    logic sendSecond;
    logic finOk;
    logic finInvalid;
    logic finErr;
  } seqStrobes_t;

endpackage

// File: rtl/addr_seq_dp.sv
module addr_seq_dp
  import addr_seq_pkg::*;
#(
  parameter int AddrW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqRead,
  output logic             isInvalid,
  output logic             isTen,
  output logic             cmdValid,
  output logic             cmdStart,
  output logic [7:0]       cmdByte,
  output logic             done,
  output logic [1:0]       status
);
  localparam int ShortBits = 7;
  localparam int LongBits  = 10;
  localparam logic [4:0] LongPrefix = 5'b11110;

  logic [AddrW-1:0] addrQ;
  logic             readQ;
  logic             overRange;
  logic             shortForm;
  logic             reservedShort;
  logic [7:0]       firstByte;
  logic [7:0]       secondByte;

  generate
    if (AddrW > LongBits) begin : g_range
      assign overRange = |addrQ[AddrW-1:LongBits];
    end else begin : g_norange
      assign overRange = 1'b0;
    end
  endgenerate

  assign shortForm     = ~|addrQ[AddrW-1:ShortBits];
  assign reservedShort = shortForm & (&addrQ[ShortBits-1:ShortBits-4]);
  assign isInvalid     = overRange | reservedShort;
  assign isTen         = ~shortForm;

  assign firstByte  = isTen ? {LongPrefix, addrQ[LongBits-1:8], readQ}
                            : {addrQ[ShortBits-1:0], readQ};
  assign secondByte = addrQ[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      readQ    <= 1'b0;
      cmdValid <= 1'b0;
      cmdStart <= 1'b0;
      cmdByte  <= '0;
      done     <= 1'b0;
      status   <= ST_OK;
    end else begin
      if (strb.load) begin
        addrQ <= reqAddr;
        readQ <= reqRead;
      end
      cmdValid <= strb.sendFirst | strb.sendSecond;
      cmdStart <= strb.sendFirst;
      if (strb.sendFirst)  cmdByte <= firstByte;
      if (strb.sendSecond) cmdByte <= secondByte;
      done <= strb.finOk | strb.finInvalid | strb.finErr;
      if (strb.finOk)      status <= ST_OK;
      if (strb.finInvalid) status <= ST_INVALID;
      if (strb.finErr)     status <= ST_BUSERR;
    end
  end

  // R4
  second_byte_plain_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdStart |-> isTen);

endmodule

// File: rtl/addr_seq_ctrl.sv
module addr_seq_ctrl
  import addr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        engDone,
  input  logic        engErr,
  input  logic        isInvalid,
  input  logic        isTen,
  output seqStrobes_t strb,
  output logic        busy
);
  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        stateNext = S_EVAL;
      end
      S_EVAL: if (isInvalid) begin
        strb.finInvalid = 1'b1;
        stateNext       = S_IDLE;
      end else begin
        strb.sendFirst = 1'b1;
        stateNext      = S_WAIT1;
      end
      S_WAIT1: if (engDone) begin
        if (engErr) begin
          strb.finErr = 1'b1;
          stateNext   = S_IDLE;
        end else if (isTen) begin
          strb.sendSecond = 1'b1;
          stateNext       = S_WAIT2;
        end else begin
          strb.finOk = 1'b1;
          stateNext  = S_IDLE;
        end
      end
      S_WAIT2: if (engDone) begin
        if (engErr) strb.finErr = 1'b1;
        else        strb.finOk  = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != S_IDLE);

  // R10
  idle_ignores_engine_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_IDLE && !reqValid |=> state == S_IDLE);

  // R9
  busy_holds_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == S_WAIT1 && !engDone |=> state == S_WAIT1);

endmodule

// File: rtl/addr_seq.sv
module addr_seq
  import addr_seq_pkg::*;
#(
  parameter int AddrW = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [AddrW-1:0] reqAddr,
  input  logic             reqRead,
  output logic             busy,
  output logic             cmdValid,
  output logic             cmdStart,
  output logic [7:0]       cmdByte,
  input  logic             engDone,
  input  logic             engErr,
  output logic             done,
  output logic [1:0]       status
);
  seqStrobes_t strb;
  logic        isInvalid;
  logic        isTen;

  addr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .engDone   (engDone),
    .engErr    (engErr),
    .isInvalid (isInvalid),
    .isTen     (isTen),
    .strb      (strb),
    .busy      (busy)
  );

  addr_seq_dp #(.AddrW(AddrW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqRead   (reqRead),
    .isInvalid (isInvalid),
    .isTen     (isTen),
    .cmdValid  (cmdValid),
    .cmdStart  (cmdStart),
    .cmdByte   (cmdByte),
    .done      (done),
    .status    (status)
  );

  // commands issued since the last accepted request, for the checks below
  logic [1:0] issuedCnt;
  logic       acceptedLong;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      issuedCnt    <= '0;
      acceptedLong <= 1'b0;
    end else if (reqValid && !busy) begin
      issuedCnt    <= '0;
      acceptedLong <= (reqAddr >= AddrW'(128));
    end else if (cmdValid && issuedCnt != 2'd3) begin
      issuedCnt <= issuedCnt + 2'd1;
    end
  end

  // R2
  invalid_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && status == ST_INVALID |-> issuedCnt == 2'd0);

  // R7
  ok_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done && status == ST_OK |-> issuedCnt == (acceptedLong ? 2'd2 : 2'd1));

  // R8
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  // R5
  second_after_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdStart |-> issuedCnt == 2'd1);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !cmdValid);

endmodule

// File: tb/addr_seq_test.sv
module addr_seq_test;
  localparam int AddrW = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic [AddrW-1:0] reqAddr = '0;
  logic             reqRead = 1'b0;
  logic             busy, cmdValid, cmdStart, done;
  logic [7:0]       cmdByte;
  logic             engDone = 1'b0;
  logic             engErr = 1'b0;
  logic [1:0]       status;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  addr_seq #(.AddrW(AddrW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqRead(reqRead), .busy(busy), .cmdValid(cmdValid), .cmdStart(cmdStart),
    .cmdByte(cmdByte), .engDone(engDone), .engErr(engErr), .done(done),
    .status(status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // mode: 0 all acknowledged, 1 first byte refused, 2 second byte refused
  task automatic runTxn(input int addr, input bit rd, input int mode,
                        input int dly, input bit intrude);
    int  expN, expStatus, n, pend, gotStatus;
    bit  inv, isLong, seenDone;
    int  expB[2];
    int  gotB[4];
    int  gotS[4];
    inv    = (addr >= 'h400) || (addr < 'h80 && (addr & 'h78) == 'h78);
    isLong = (addr >= 'h80);
    expB[0] = isLong ? ('hF0 | (((addr >> 8) & 3) << 1) | int'(rd))
                     : (((addr << 1) | int'(rd)) & 'hFF);
    expB[1] = addr & 'hFF;
    if (inv) begin expN = 0; expStatus = 1; end
    else if (mode == 1) begin expN = 1; expStatus = 2; end
    else if (isLong) begin expN = 2; expStatus = (mode == 2) ? 2 : 0; end
    else begin expN = 1; expStatus = 0; end

    @(negedge clk);
    reqValid = 1'b1; reqAddr = AddrW'(addr); reqRead = rd;
    n = 0; pend = 0; seenDone = 1'b0; gotStatus = 0;
    for (int k = 0; k < 40 && !seenDone; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
      engDone  = 1'b0;
      engErr   = 1'b0;
      if (done) begin
        seenDone  = 1'b1;
        gotStatus = int'(status);
      end else if (cmdValid) begin
        if (n < 4) begin gotB[n] = int'(cmdByte); gotS[n] = int'(cmdStart); end
        // R9
        check(busy == 1'b1, "R9 busy while byte pending", int'(busy), 1);
        if (intrude && n == 0) begin
          reqValid = 1'b1; reqAddr = AddrW'(addr ^ 'h0A5); reqRead = ~rd;
        end
        n++;
        pend = dly;
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          engDone = 1'b1;
          engErr  = (mode == 1 && n == 1) || (mode == 2 && n == 2);
        end
      end
    end
    // R7
    check(seenDone, "R7 done seen", int'(seenDone), 1);
    // R2 R3 R5 R8
    check(n == expN, inv ? "R2/R3 command count" : "R5/R8 command count", n, expN);
    // R7 R6 R2 R3
    check(gotStatus == expStatus, "R7 status", gotStatus, expStatus);
    if (n >= 1 && expN >= 1) begin
      // R1 R4
      check(gotB[0] == expB[0], isLong ? "R4 first byte" : "R1 short byte", gotB[0], expB[0]);
      check(gotS[0] == 1, "R1 start on first byte", gotS[0], 1);
    end
    if (n >= 2 && expN >= 2) begin
      // R4
      check(gotB[1] == expB[1], "R4 second byte", gotB[1], expB[1]);
      check(gotS[1] == 0, "R4 no start on second byte", gotS[1], 0);
    end
    @(negedge clk);
    // R7 one-cycle pulse
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000 && !finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !cmdValid && !done, "R7 reset state", {busy, cmdValid, done}, 0);

    // R10: engine completion while idle
    engDone = 1'b1; engErr = 1'b1;
    @(negedge clk);
    engDone = 1'b0; engErr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!done && !cmdValid && !busy, "R10 idle engine pulse ignored",
            {busy, cmdValid, done}, 0);
    end

    // R9: request arriving mid-sequence
    runTxn('h2C7, 1'b0, 0, 3, 1'b1);
    runTxn('h05A, 1'b1, 0, 2, 1'b1);

    // full sweep, all acknowledged (R1 R2 R3 R4)
    for (int a = 0; a < (1 << AddrW); a++)
      for (int r = 0; r < 2; r++)
        runTxn(a, r[0], 0, 1 + (a % 3), 1'b0);

    // refusal sweeps (R5 R6)
    for (int m = 1; m <= 2; m++)
      for (int a = 0; a < 'h480; a++)
        runTxn(a, a[4], m, 1 + (a % 2), 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule